// File: doc/BRIEF.md
# Reloadable Interval Down-Counter

This block is a 16-bit interval timer that counts down by one on every system clock while it is running. When the count reaches zero it reloads from a reload value driven by registers outside the block. It then either keeps going (free-running) or stops itself (single-pass). A byte-wide control strobe starts and stops the timer, selects the mode and can force an immediate load of the reload value at any moment.

The reload value is not copied into the block. Every load, whether automatic or forced, takes whatever is on the reload input in that cycle. The owner of the reload registers is expected to reset them to all ones.

Software sees the live counter one byte at a time through a byte-select input, with no snapshot taken between the two byte reads. It also sees a control readback byte that merges live status with the last byte written.

Top module: `itmr_top`

## Requirements
- R1: After synchronous reset the counter is 0, run and single-pass status are 0, the zero flag is 1 and the control readback is 0x10.
- R2: While running with a non-zero count and no forced load, the counter drops by exactly one per clock.
- R3: While running with a count of zero and no forced load, the next clock loads the counter from the reload input, and a free-running timer keeps counting from there.
- R4: A control write with bit 4 set loads the reload input into the counter on that clock, whether the timer is running or stopped, ahead of decrement and auto-reload.
- R5: Run status (control bit 0) and mode (control bit 3, 1 = single-pass) change only on a control write.
- R6: In single-pass mode a zero count clears run status on the next clock, even if a control write in that same cycle tries to set it.
- R7: The zero flag is 1 exactly when the counter value is 0.
- R8: Control readback shows run status at bit 0, mode at bit 3 and a constant 1 at bit 4. Bits 7:5 and 2:1 show the last byte written.
- R9: With byte select at 0 the byte output shows counter bits 7:0, and with it at 1 it shows bits 15:8. The byte output always reflects the live count.
- R10: A stopped timer holds its count unless a forced load occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reload_val | input | 16 | Live reload value from external registers |
| ctl_wr | input | 1 | Control write strobe |
| ctl_data | input | 8 | Control byte (bit 0 run, bit 3 single-pass, bit 4 force load) |
| rd_hi | input | 1 | Byte select for counter readout |
| count_o | output | 16 | Live counter value |
| run_o | output | 1 | Run status |
| oneshot_o | output | 1 | Mode status, 1 = single-pass |
| zero_o | output | 1 | Counter-is-zero flag |
| ctl_rb_o | output | 8 | Control readback byte |
| cnt_byte_o | output | 8 | Selected byte of live counter |

## Verification
A corrupted counter shows up on count_o and cnt_byte_o on the very next clock. If the count is wrong when it hits zero, the error also spreads to the reload instant and to the one-shot stop, so the bench compares every output every cycle against a model. A wrong run or mode bit appears at once on run_o, oneshot_o and ctl_rb_o, and within one cycle as a missing or extra decrement. A zero flag out of step with the count shows in the same cycle, and the checker compares the two registers directly.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
  localparam int CB_RUN   = 0;
  localparam int CB_MODE  = 3;
  localparam int CB_LOAD  = 4;
  localparam int CB_FIXED = 4;

  typedef struct packed {
    logic run;
    logic oneshot;
    logic load;
  } ctl_cmd_t;

  function automatic ctl_cmd_t decode_ctl(input logic [7:0] b);
    ctl_cmd_t c;
    c.run     = b[CB_RUN];
    c.oneshot = b[CB_MODE];
    c.load    = b[CB_LOAD];
    return c;
  endfunction
endpackage

// File: rtl/itmr_ctl.sv
module itmr_ctl
  import itmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr,
  input  logic [7:0] wdata,
  input  logic       cnt_zero,
  output logic       run,
  output logic       oneshot,
  output logic       force_ld,
  output logic [7:0] shadow
);
  ctl_cmd_t cmd;
  assign cmd      = decode_ctl(wdata);
  assign force_ld = wr & cmd.load;

  always_ff @(posedge clk) begin
    if (rst) begin
      run     <= 1'b0;
      oneshot <= 1'b0;
      shadow  <= 8'h00;
    end else begin
      if (cnt_zero && oneshot)
        run <= 1'b0;
      else if (wr)
        run <= cmd.run;
      if (wr) begin
        oneshot <= cmd.oneshot;
        shadow  <= wdata;
      end
    end
  end
endmodule

// File: rtl/itmr_cnt.sv
module itmr_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] reload,
  input  logic         force_ld,
  input  logic         run,
  output logic [W-1:0] count,
  output logic         zero
);
  logic [W-1:0] nxt;
  logic         at_zero;

  assign at_zero = (count == '0);

  always_comb begin
    nxt = count;
    if (force_ld)
      nxt = reload;
    else if (run && !at_zero)
      nxt = count - 1'b1;
    else if (run)
      nxt = reload;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      zero  <= 1'b1;
    end else begin
      count <= nxt;
      zero  <= (nxt == '0);
    end
  end
endmodule

// File: rtl/itmr_top.sv
module itmr_top
  import itmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] reload_val,
  input  logic         ctl_wr,
  input  logic [7:0]   ctl_data,
  input  logic         rd_hi,
  output logic [W-1:0] count_o,
  output logic         run_o,
  output logic         oneshot_o,
  output logic         zero_o,
  output logic [7:0]   ctl_rb_o,
  output logic [7:0]   cnt_byte_o
);
  localparam int CW = (W > 16) ? W : 16;

  logic       force_ld;
  logic [7:0] shadow;
  logic [CW-1:0] cnt_ext;

  itmr_ctl u_ctl (
    .clk(clk), .rst(rst), .wr(ctl_wr), .wdata(ctl_data),
    .cnt_zero(count_o == '0), .run(run_o), .oneshot(oneshot_o),
    .force_ld(force_ld), .shadow(shadow)
  );

  itmr_cnt #(.W(W)) u_cnt (
    .clk(clk), .rst(rst), .reload(reload_val), .force_ld(force_ld),
    .run(run_o), .count(count_o), .zero(zero_o)
  );

  always_comb begin
    ctl_rb_o           = shadow;
    ctl_rb_o[CB_RUN]   = run_o;
    ctl_rb_o[CB_MODE]  = oneshot_o;
    ctl_rb_o[CB_FIXED] = 1'b1;
  end

  assign cnt_ext    = CW'(count_o);
  assign cnt_byte_o = rd_hi ? cnt_ext[15:8] : cnt_ext[7:0];
endmodule

// File: rtl/itmr_chk.sv
module itmr_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] reload_val,
  input logic         ctl_wr,
  input logic [7:0]   ctl_data,
  input logic [W-1:0] count_o,
  input logic         run_o,
  input logic         oneshot_o,
  input logic         zero_o,
  input logic [7:0]   ctl_rb_o
);
  logic fl;
  assign fl = ctl_wr & ctl_data[4];

  AST_ZERO_MATCH: assert property (@(posedge clk) disable iff (rst)
    zero_o == (count_o == '0)); // R7
  AST_DECREMENT: assert property (@(posedge clk) disable iff (rst)
    (run_o && count_o != '0 && !fl) |=> count_o == $past(count_o) - 1'b1); // R2
  AST_AUTO_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (run_o && count_o == '0 && !fl) |=> count_o == $past(reload_val)); // R3
  AST_FORCE_LOAD: assert property (@(posedge clk) disable iff (rst)
    fl |=> count_o == $past(reload_val)); // R4
  AST_MODE_STABLE: assert property (@(posedge clk) disable iff (rst)
    !ctl_wr |=> $stable(oneshot_o)); // R5
  AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (rst)
    (oneshot_o && count_o == '0) |=> !run_o); // R6
  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (rst)
    (!run_o && !fl) |=> $stable(count_o)); // R10
  AST_READBACK: assert property (@(posedge clk) disable iff (rst)
    ctl_rb_o[4] && ctl_rb_o[0] == run_o && ctl_rb_o[3] == oneshot_o); // R8
endmodule

bind itmr_top itmr_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .reload_val(reload_val), .ctl_wr(ctl_wr),
  .ctl_data(ctl_data), .count_o(count_o), .run_o(run_o),
  .oneshot_o(oneshot_o), .zero_o(zero_o), .ctl_rb_o(ctl_rb_o)
);

// File: tb/itmr_top_tb_top.sv
module itmr_top_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] reload_val;
  logic        ctl_wr;
  logic [7:0]  ctl_data;
  logic        rd_hi;
  logic [15:0] count_o;
  logic        run_o, oneshot_o, zero_o;
  logic [7:0]  ctl_rb_o, cnt_byte_o;

  int n_chk = 0;
  int n_bad = 0;

  logic [15:0] m_cnt;
  logic        m_run, m_os;
  logic [7:0]  m_sh;

  always #10 clk = ~clk;

  itmr_top dut_i (
    .clk(clk), .rst(rst), .reload_val(reload_val), .ctl_wr(ctl_wr),
    .ctl_data(ctl_data), .rd_hi(rd_hi), .count_o(count_o), .run_o(run_o),
    .oneshot_o(oneshot_o), .zero_o(zero_o), .ctl_rb_o(ctl_rb_o),
    .cnt_byte_o(cnt_byte_o)
  );

  function automatic logic [7:0] exp_rb(input logic [7:0] sh, input logic r, input logic o);
    return {sh[7:5], 1'b1, o, sh[2:1], r};
  endfunction

  function automatic logic [7:0] exp_byte(input logic [15:0] c, input logic hi);
    return hi ? c[15:8] : c[7:0];
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R2/R3/R4 count", count_o, m_cnt);
    chk("R5/R6 run", 16'(run_o), 16'(m_run));
    chk("R5 mode", 16'(oneshot_o), 16'(m_os));
    chk("R7 zero", 16'(zero_o), 16'(m_cnt == 16'h0));
    chk("R8 readback", 16'(ctl_rb_o), 16'(exp_rb(m_sh, m_run, m_os)));
    chk("R9 byte", 16'(cnt_byte_o), 16'(exp_byte(m_cnt, rd_hi)));
  endtask

  // one clock: inputs already driven; advance model from requirements
  task automatic step();
    logic f, z;
    logic [15:0] n_cnt;
    logic n_run;
    @(posedge clk);
    f = ctl_wr & ctl_data[4];
    z = (m_cnt == 16'h0);
    n_cnt = f ? reload_val : (m_run ? (z ? reload_val : m_cnt - 16'd1) : m_cnt);
    n_run = (z && m_os) ? 1'b0 : (ctl_wr ? ctl_data[0] : m_run);
    if (ctl_wr) begin
      m_os = ctl_data[3];
      m_sh = ctl_data;
    end
    m_cnt = n_cnt;
    m_run = n_run;
    @(negedge clk);
    compare_all();
    ctl_wr = 1'b0;
  endtask

  task automatic write_ctl(input logic [7:0] d);
    ctl_wr = 1'b1;
    ctl_data = d;
    step();
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    rst = 1'b1; reload_val = 16'hFFFF; ctl_wr = 1'b0; ctl_data = 8'h00; rd_hi = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_cnt = 16'h0; m_run = 1'b0; m_os = 1'b0; m_sh = 8'h00;
    // R1 reset state
    chk("R1 count", count_o, 16'h0);
    chk("R1 run", 16'(run_o), 16'h0);
    chk("R1 zero", 16'(zero_o), 16'h1);
    chk("R1 readback", 16'(ctl_rb_o), 16'h0010);

    // R4 force load + start, free-running; R2 decrement; R3 reload
    reload_val = 16'd5;
    write_ctl(8'h11);
    chk("R4 forced load", count_o, 16'd5);
    repeat (5) step();
    chk("R2 reached zero", count_o, 16'd0);
    chk("R7 zero flag", 16'(zero_o), 16'h1);
    step();
    chk("R3 auto reload", count_o, 16'd5);
    chk("R3 still running", 16'(run_o), 16'h1);

    // R6 single-pass stops at zero
    reload_val = 16'd3;
    write_ctl(8'h19);
    repeat (3) step();
    chk("R6 at zero", count_o, 16'd0);
    step();
    chk("R6 run cleared", 16'(run_o), 16'h0);
    chk("R6 reloaded", count_o, 16'd3);
    // R10 hold while stopped
    repeat (4) step();
    chk("R10 held", count_o, 16'd3);

    // R6 priority over a start write when count is zero
    reload_val = 16'd0;
    write_ctl(8'h18);
    chk("R4 load zero", count_o, 16'd0);
    write_ctl(8'h09);
    chk("R6 start ignored", 16'(run_o), 16'h0);

    // R8 readback merge
    write_ctl(8'hE6);
    chk("R8 merged", 16'(ctl_rb_o), 16'h00F6);

    // R9 byte readout
    reload_val = 16'hA53C;
    write_ctl(8'h10);
    rd_hi = 1'b0; #1; chk("R9 low", 16'(cnt_byte_o), 16'h003C);
    rd_hi = 1'b1; #1; chk("R9 high", 16'(cnt_byte_o), 16'h00A5);

    // constrained random phase
    for (int i = 0; i < 4000; i++) begin
      ctl_wr   = ($urandom_range(0, 7) == 0);
      ctl_data = 8'($urandom());
      rd_hi    = 1'($urandom());
      reload_val = ($urandom_range(0, 15) == 0) ? 16'($urandom()) : 16'($urandom_range(0, 12));
      step();
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule